// File: doc/BRIEF.md
# Chained Serial Character Digit

This block is one position in a row of seven-segment digits that all hang off a single serial line. Each position receives 8N1 characters on `ser_in` and keeps the first character of a message for itself. It hands every later character to the next position on `ser_out`. The next position therefore sees a message that is one character shorter. When a message carries more characters than there are positions, every position shows exactly one character and the surplus leaves the last position's output.

Forwarding uses no second transmitter. `ser_out` is held at the idle level (1) until the kept character has been checked. After that, `ser_out` is the raw `ser_in` wire, so later characters keep their original timing exactly. If the input stays high for the idle timeout, the message is over: the output goes back to constant 1 and the node waits for a new first character.

The receiver has five states. `RX_IDLE` hunts for a low level. `RX_START` confirms the start bit at its centre, or drops back to `RX_IDLE` on a glitch. `RX_DATA` samples eight bits, LSB first. `RX_STOP` checks the stop bit and produces either a character strobe or a framing error. `RX_WAITHI` follows a framing error and waits for the line to go high. The framer has two states. `FR_ARMED` moves to `FR_PASS` on a valid character, which is latched for the display. `FR_PASS` moves back to `FR_ARMED` when the line has been high for the whole timeout. A low level in `FR_PASS` restarts the timer.

Top module: `chain_digit_node`

## Requirements
- R1: Reset gives `seg`=0, `dp`=0 and `ser_out`=1.
- R2: The first valid character after arming is latched. `seg` shows the decode of bits 6:0 and `dp` equals bit 7. Both are valid before the end of that character's stop bit.
- R3: While armed, and during the whole first character, `ser_out` stays 1. The kept character is never forwarded.
- R4: Once the first character has been accepted, `ser_out` equals `ser_in` in the same cycle.
- R5: During a message, a high gap shorter than the timeout does not end it. Later characters are forwarded and leave `seg`/`dp` unchanged.
- R6: When the line stays high for IDLE_US microseconds (counted in clock cycles), the node re-arms. `ser_out` returns to 1 and the next character is latched.
- R7: Decoding is active high, with bit 0 = segment a through bit 6 = segment g. Digits 0..9 give 3F,06,5B,4F,66,6D,7D,07,7F,6F. Space gives 00 and minus gives 40. Upper/lower case: A/a 77, B/b 7C, C 39, c 58, D/d 5E, E/e 79, F/f 71, H 76, h 74, L/l 38, N/n 54, O 3F, o 5C, P/p 73, R/r 50, T/t 78, U 3E, u 1C, Y/y 6E. Every other code gives 00.
- R8: A character whose stop bit is low is discarded. The display stays as it was and the gate stays closed. No new start is hunted until the line has been high again.
- R9: In a chain, the second node shows the message's second character. Characters beyond the chain length appear on the last node's `ser_out`.
- R10: A low pulse shorter than half a bit is rejected as a start bit and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial input, idle high |
| ser_out | output | 1 | Downstream serial line: constant 1 or pass-through of `ser_in` |
| seg | output | 7 | Segment drive, bit 0 = a ... bit 6 = g, active high |
| dp | output | 1 | Decimal point, active high |

## Verification
A framer stuck in `FR_PASS`, or one that opens too early, shows up on `ser_out` as the zero bits of the kept character, within the first character time. A gate that never opens leaves `ser_out` high during the second character, and a chained second node then shows the wrong digit one character later. A miscounted idle timer shows up at the next message: either the first character is forwarded instead of displayed, or a short gap wrongly replaces the digit. Receiver state errors give a wrong `seg`/`dp` pattern by the end of the affected stop bit.

// File: rtl/node_pkg.sv
`timescale 1ns/1ps
package node_pkg;
    localparam int OS_RATE   = 16;
    localparam int DATA_BITS = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAITHI
    } rx_state_t;

    typedef enum logic {
        FR_ARMED,
        FR_PASS
    } fr_state_t;
endpackage

// File: rtl/node_uart_rx.sv
`timescale 1ns/1ps
module node_uart_rx
    import node_pkg::*;
#(
    parameter int DIV = 651
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_in,
    output logic                 line_s,
    output logic                 valid,
    output logic                 ferr,
    output logic [DATA_BITS-1:0] data
);
    localparam int DW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int OSW  = $clog2(OS_RATE);
    localparam int BW   = $clog2(DATA_BITS);
    localparam int HALF = OS_RATE / 2;

    logic [1:0]           sync_q;
    logic [DW-1:0]        div_q;
    logic                 tick;
    rx_state_t            st_q, st_n;
    logic [OSW-1:0]       os_q, os_n;
    logic [BW-1:0]        bit_q, bit_n;
    logic [DATA_BITS-1:0] sh_q, sh_n;
    logic                 vld_q, vld_n, fer_q, fer_n;

    assign line_s = sync_q[1];
    assign tick   = (div_q == DW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            div_q  <= '0;
            st_q   <= RX_IDLE;
            os_q   <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            vld_q  <= 1'b0;
            fer_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ser_in};
            div_q  <= tick ? '0 : div_q + 1'b1;
            st_q   <= st_n;
            os_q   <= os_n;
            bit_q  <= bit_n;
            sh_q   <= sh_n;
            vld_q  <= vld_n;
            fer_q  <= fer_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        os_n  = os_q;
        bit_n = bit_q;
        sh_n  = sh_q;
        vld_n = 1'b0;
        fer_n = 1'b0;
        if (tick) begin
            unique case (st_q)
                RX_IDLE: begin
                    if (!line_s) begin
                        st_n = RX_START;
                        os_n = '0;
                    end
                end
                RX_START: begin
                    if (os_q == OSW'(HALF - 1)) begin
                        os_n = '0;
                        if (!line_s) begin
                            st_n  = RX_DATA;
                            bit_n = '0;
                        end else begin
                            st_n = RX_IDLE;
                        end
                    end else begin
                        os_n = os_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (os_q == OSW'(OS_RATE - 1)) begin
                        os_n = '0;
                        sh_n = {line_s, sh_q[DATA_BITS-1:1]};
                        if (bit_q == BW'(DATA_BITS - 1)) st_n = RX_STOP;
                        else bit_n = bit_q + 1'b1;
                    end else begin
                        os_n = os_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (os_q == OSW'(OS_RATE - 1)) begin
                        os_n = '0;
                        if (line_s) begin
                            vld_n = 1'b1;
                            st_n  = RX_IDLE;
                        end else begin
                            fer_n = 1'b1;
                            st_n  = RX_WAITHI;
                        end
                    end else begin
                        os_n = os_q + 1'b1;
                    end
                end
                RX_WAITHI: begin
                    if (line_s) st_n = RX_IDLE;
                end
                default: st_n = RX_IDLE;
            endcase
        end
    end

    always_comb begin
        valid = vld_q;
        ferr  = fer_q;
        data  = sh_q;
    end

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vld_q, fer_q}));

    // R8
    no_hunt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_WAITHI && !line_s) |=> (st_q == RX_WAITHI));

    // R10
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_START && tick && os_q == OSW'(HALF - 1) && line_s) |=> (st_q == RX_IDLE));
endmodule

// File: rtl/node_framer.sv
`timescale 1ns/1ps
module node_framer
    import node_pkg::*;
#(
    parameter int IDLE_CYC = 10_000_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_s,
    input  logic                 rx_valid,
    input  logic [DATA_BITS-1:0] rx_byte,
    output logic                 gate,
    output logic [DATA_BITS-1:0] held
);
    localparam int IW = $clog2(IDLE_CYC + 1);
    localparam logic [DATA_BITS-1:0] BLANK_CODE = 8'h20;

    fr_state_t            st_q, st_n;
    logic [IW-1:0]        idle_q, idle_n;
    logic [DATA_BITS-1:0] held_q;
    logic                 load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= FR_ARMED;
            idle_q <= '0;
        end else begin
            st_q   <= st_n;
            idle_q <= idle_n;
        end
    end

    always_comb begin
        st_n   = st_q;
        idle_n = idle_q;
        unique case (st_q)
            FR_ARMED: begin
                idle_n = '0;
                if (rx_valid) st_n = FR_PASS;
            end
            FR_PASS: begin
                if (!line_s) begin
                    idle_n = '0;
                end else if (idle_q == IW'(IDLE_CYC - 1)) begin
                    idle_n = '0;
                    st_n   = FR_ARMED;
                end else begin
                    idle_n = idle_q + 1'b1;
                end
            end
            default: st_n = FR_ARMED;
        endcase
    end

    always_comb begin
        load = (st_q == FR_ARMED) && rx_valid;
        gate = (st_q == FR_PASS);
        held = held_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    held_q <= BLANK_CODE;
        else if (load) held_q <= rx_byte;
    end

    // R2
    latch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (held_q == $past(rx_byte)) && (st_q == FR_PASS));

    // R5
    hold_display_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held_q));

    // R5
    pass_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FR_PASS && !line_s) |=> (st_q == FR_PASS));

    // R6
    rearm_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q == FR_PASS) |-> $past(line_s));
endmodule

// File: rtl/node_seg_decode.sv
`timescale 1ns/1ps
module node_seg_decode (
    input  logic [6:0] code,
    output logic [6:0] seg
);
    always_comb begin
        case (code)
            7'h30:        seg = 7'h3F;
            7'h31:        seg = 7'h06;
            7'h32:        seg = 7'h5B;
            7'h33:        seg = 7'h4F;
            7'h34:        seg = 7'h66;
            7'h35:        seg = 7'h6D;
            7'h36:        seg = 7'h7D;
            7'h37:        seg = 7'h07;
            7'h38:        seg = 7'h7F;
            7'h39:        seg = 7'h6F;
            7'h2D:        seg = 7'h40;
            7'h41, 7'h61: seg = 7'h77;
            7'h42, 7'h62: seg = 7'h7C;
            7'h43:        seg = 7'h39;
            7'h63:        seg = 7'h58;
            7'h44, 7'h64: seg = 7'h5E;
            7'h45, 7'h65: seg = 7'h79;
            7'h46, 7'h66: seg = 7'h71;
            7'h48:        seg = 7'h76;
            7'h68:        seg = 7'h74;
            7'h4C, 7'h6C: seg = 7'h38;
            7'h4E, 7'h6E: seg = 7'h54;
            7'h4F:        seg = 7'h3F;
            7'h6F:        seg = 7'h5C;
            7'h50, 7'h70: seg = 7'h73;
            7'h52, 7'h72: seg = 7'h50;
            7'h54, 7'h74: seg = 7'h78;
            7'h55:        seg = 7'h3E;
            7'h75:        seg = 7'h1C;
            7'h59, 7'h79: seg = 7'h6E;
            default:      seg = 7'h00;
        endcase
    end
endmodule

// File: rtl/chain_digit_node.sv
`timescale 1ns/1ps
module chain_digit_node
    import node_pkg::*;
#(
    parameter int CLK_HZ  = 200_000_000,
    parameter int BAUD    = 19_200,
    parameter int IDLE_US = 50_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_in,
    output logic       ser_out,
    output logic [6:0] seg,
    output logic       dp
);
    localparam int DIV      = CLK_HZ / (BAUD * OS_RATE);
    localparam int IDLE_CYC = int'((longint'(CLK_HZ) * longint'(IDLE_US)) / 64'd1000000);

    logic                 line_s, rx_valid, rx_ferr, gate;
    logic [DATA_BITS-1:0] rx_byte, held;

    node_uart_rx #(.DIV(DIV)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .ser_in (ser_in),
        .line_s (line_s),
        .valid  (rx_valid),
        .ferr   (rx_ferr),
        .data   (rx_byte)
    );

    node_framer #(.IDLE_CYC(IDLE_CYC)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s   (line_s),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .gate     (gate),
        .held     (held)
    );

    node_seg_decode u_dec (
        .code (held[6:0]),
        .seg  (seg)
    );

    assign dp      = held[DATA_BITS-1];
    assign ser_out = gate ? ser_in : 1'b1;

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> ser_out);

    // R4
    follow_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (ser_out == ser_in));

    // R8
    ferr_keeps_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ferr && !gate) |=> !gate);
endmodule

// File: tb/sim_chain_digit_node.sv
`timescale 1ns/1ps
module sim_chain_digit_node;
    localparam int CLK_HZ  = 3_200_000;
    localparam int BAUD    = 100_000;
    localparam int IDLE_US = 200;
    localparam int BITC    = 32;
    localparam int LONG_GAP  = 800;
    localparam int SHORT_GAP = 200;

    logic clk = 1'b0, rst_n = 1'b0, ser_in = 1'b1;
    logic ser_mid, ser_end, dp0, dp1;
    logic [6:0] seg0, seg1;
    int errors = 0, checks = 0;
    bit bad0, bad1, done = 1'b0;
    logic [7:0] exp0, exp1;
    string cs = "0123456789AaBbCcDdEeFfHhLlNnOoPpRrTtUuYy -#@Qz";

    always #2.5 clk = ~clk;

    chain_digit_node #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .IDLE_US(IDLE_US)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(ser_mid), .seg(seg0), .dp(dp0));
    chain_digit_node #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .IDLE_US(IDLE_US)) u1 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_mid), .ser_out(ser_end), .seg(seg1), .dp(dp1));

    function automatic logic [6:0] dec(input logic [6:0] c);
        case (c)
            7'h30: return 7'h3F; 7'h31: return 7'h06; 7'h32: return 7'h5B;
            7'h33: return 7'h4F; 7'h34: return 7'h66; 7'h35: return 7'h6D;
            7'h36: return 7'h7D; 7'h37: return 7'h07; 7'h38: return 7'h7F;
            7'h39: return 7'h6F; 7'h2D: return 7'h40; 7'h20: return 7'h00;
            7'h41, 7'h61: return 7'h77; 7'h42, 7'h62: return 7'h7C;
            7'h43: return 7'h39; 7'h63: return 7'h58;
            7'h44, 7'h64: return 7'h5E; 7'h45, 7'h65: return 7'h79;
            7'h46, 7'h66: return 7'h71; 7'h48: return 7'h76; 7'h68: return 7'h74;
            7'h4C, 7'h6C: return 7'h38; 7'h4E, 7'h6E: return 7'h54;
            7'h4F: return 7'h3F; 7'h6F: return 7'h5C;
            7'h50, 7'h70: return 7'h73; 7'h52, 7'h72: return 7'h50;
            7'h54, 7'h74: return 7'h78; 7'h55: return 7'h3E; 7'h75: return 7'h1C;
            7'h59, 7'h79: return 7'h6E;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [7:0] shown(input logic [7:0] b);
        return {b[7], dec(b[6:0])};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // mode: 0 expect idle level, 1 expect copy of ser_in, 2 no check
    task automatic send_byte(input logic [7:0] b, input logic stopv, input int m0, input int m1);
        logic [9:0] fr;
        fr = {stopv, b, 1'b0};
        bad0 = 1'b0;
        bad1 = 1'b0;
        for (int i = 0; i < 10; i++) begin
            ser_in = fr[i];
            cyc(BITC / 2);
            if (m0 == 0 && ser_mid !== 1'b1) bad0 = 1'b1;
            if (m0 == 1 && ser_mid !== ser_in) bad0 = 1'b1;
            if (m1 == 0 && ser_end !== 1'b1) bad1 = 1'b1;
            if (m1 == 1 && ser_end !== ser_in) bad1 = 1'b1;
            cyc(BITC / 2);
        end
    endtask

    task automatic check_disp(input string req);
        chk({dp0, seg0} === shown(exp0), req, {dp0, seg0}, shown(exp0));
        chk({dp1, seg1} === shown(exp1), req, {dp1, seg1}, shown(exp1));
    endtask

    task automatic send_msg(input logic [7:0] m [4], input int len);
        for (int i = 0; i < len; i++) begin
            send_byte(m[i], 1'b1, (i == 0) ? 0 : 1, (i <= 1) ? 0 : 1);
            if (i == 0) begin
                exp0 = m[0];
                chk(!bad0, "R3 first char not forwarded", bad0, 0);
                chk({dp0, seg0} === shown(exp0), "R2 first char latched", {dp0, seg0}, shown(exp0));
            end else begin
                chk(!bad0, "R4 pass-through", bad0, 0);
            end
            if (i == 1) begin
                exp1 = m[1];
                chk({dp1, seg1} === shown(exp1), "R9 second node shows second char", {dp1, seg1}, shown(exp1));
            end
            if (i >= 2) chk(!bad1, "R9 surplus leaves chain", bad1, 0);
        end
        check_disp("R5 display held to message end");
        cyc(LONG_GAP);
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] msg [4];
        int len;
        void'($urandom(32'd7123));
        exp0 = 8'h20;
        exp1 = 8'h20;
        cyc(5);
        // R1 during and after reset
        chk({ser_mid, dp0, seg0} === 9'h100, "R1 reset state", {ser_mid, dp0, seg0}, 9'h100);
        rst_n = 1'b1;
        cyc(10);
        chk({ser_mid, dp0, seg0} === 9'h100, "R1 after reset", {ser_mid, dp0, seg0}, 9'h100);

        // directed message, dot on '1'
        msg[0] = 8'h37; msg[1] = 8'hB1; msg[2] = 8'h32; msg[3] = 8'h33;
        send_msg(msg, 4);

        // R5 short gap continues, R6 long gap re-arms
        send_byte(8'h41, 1'b1, 0, 0);
        exp0 = 8'h41;
        cyc(SHORT_GAP);
        send_byte(8'h62, 1'b1, 1, 0);
        exp1 = 8'h62;
        chk(!bad0, "R5 short gap still forwards", bad0, 0);
        check_disp("R5 short gap keeps display");
        cyc(LONG_GAP);
        chk(ser_mid === 1'b1, "R6 idle level after timeout", ser_mid, 1);
        send_byte(8'h2D, 1'b1, 0, 0);
        exp0 = 8'h2D;
        chk(!bad0, "R6 re-armed, not forwarded", bad0, 0);
        check_disp("R6 new first char after timeout");
        cyc(LONG_GAP);

        // R8 framing error
        send_byte(8'h38, 1'b0, 0, 0);
        ser_in = 1'b0;
        cyc(BITC * 2);
        chk(ser_mid === 1'b1, "R8 gate closed after bad stop", ser_mid, 1);
        ser_in = 1'b1;
        cyc(LONG_GAP);
        check_disp("R8 bad char discarded");
        send_byte(8'h35, 1'b1, 0, 0);
        exp0 = 8'h35;
        chk(!bad0, "R8 next good char kept", bad0, 0);
        check_disp("R8 next good char shown");
        cyc(LONG_GAP);

        // R10 short glitch
        ser_in = 1'b0;
        cyc(BITC / 4);
        ser_in = 1'b1;
        cyc(LONG_GAP);
        check_disp("R10 glitch ignored");
        send_byte(8'hC3, 1'b1, 0, 0);
        exp0 = 8'hC3;
        chk(!bad0, "R10 gate closed after glitch", bad0, 0);
        check_disp("R10 char after glitch");
        cyc(LONG_GAP);

        // R7 unmapped code blanks
        send_byte(8'h23, 1'b1, 0, 0);
        exp0 = 8'h23;
        chk(seg0 === 7'h00, "R7 unmapped blank", seg0, 0);
        cyc(LONG_GAP);

        // random messages, R7 decode over the charset
        for (int k = 0; k < 40; k++) begin
            len = $urandom_range(1, 4);
            for (int j = 0; j < 4; j++) begin
                msg[j] = {1'($urandom_range(0, 1)), cs[$urandom_range(0, cs.len() - 1)][6:0]};
            end
            send_msg(msg, len);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule